// File: doc/BRIEF.md
# Double-Buffered Octal Code Register Bank

This block sits behind a serial word receiver and holds the digital side of an eight-channel converter. Each channel has two 8-bit registers. A staging register takes new codes. An output register drives the converter code for that channel. Each received 16-bit word carries an opcode, and the opcode decides how the two sets of registers and the channel enable state change. A word can also pass through with no effect, which lets several of these blocks share one daisy chain.

The block also holds a per-channel output-enable mask with a full-power-down flag, and the phase bit that the serial front end uses to choose which clock edge launches its output data. The active-low `load_n` pin may change at any time. The block synchronizes it into the clock domain. While it is held low, every output register tracks its staging register. Analog conversion is outside this block.

Top module: `octal_code_bank`

## Requirements
- R1: Word layout, most significant bit first: bits [15:14] are ignored, bits [13:11] are the channel address, bits [10:8] are the opcode and bits [7:0] are the data byte. A word strobed by `word_valid` at one rising edge is applied at the next rising edge.
- R2: Opcode 000 changes no register.
- R3: Opcode 001 sets every staging and output code to zero. It also sets all bits of `en_mask` and clears `all_off`.
- R4: Opcode 010 copies the data byte into `en_mask`, where a 0 bit disables that channel. It drives `all_off` high exactly when the byte is zero, and it leaves all codes unchanged.
- R5: Opcode 011 sets `phase_rise` to address bit 13 (0 = falling edge, 1 = rising edge) and copies every staging register into its output register. `phase_rise` changes only through this opcode or reset.
- R6: Opcode 100 writes the data byte into all eight output registers. It leaves the staging registers unchanged, sets all bits of `en_mask` and clears `all_off`.
- R7: Opcode 101 writes the data byte into the addressed staging register only. No output register changes.
- R8: Opcode 110 writes the data byte into both the addressed staging register and the addressed output register. It sets all bits of `en_mask` and clears `all_off`.
- R9: Opcode 111 copies every staging register into its output register and leaves `en_mask` unchanged.
- R10: `load_n` passes through two synchronizer flops. Starting from the third rising edge after it goes low, every output register takes its staging value on each edge. In the edge where an opcode writes an output register directly, that write takes priority over the copy.
- R11: After reset every code is zero, `en_mask` is all ones, `all_off` is low and `phase_rise` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid | input | 1 | One-cycle strobe marking a complete received word |
| word | input | 16 | Received command word |
| load_n | input | 1 | Asynchronous active-low level-sensitive transfer pin |
| dac_codes | output | 64 | Output codes, channel i at bits [8i+7:8i] |
| en_mask | output | 8 | Per-channel enable, 1 = enabled |
| all_off | output | 1 | High when every channel is disabled |
| phase_rise | output | 1 | Serial output launch edge, 1 = rising |

## Verification
The bound checker checks several rules on every cycle. It confirms that a no-operation, a staging-only write or any cycle without a phase command leaves the relevant outputs steady. It confirms that a clear zeroes every output code, that `all_off` agrees with the mask, and that a held-low `load_n` makes the outputs equal the staging registers. The bench sweeps every opcode at every address, with data bytes that are computed from the loop indices and predicted by an arithmetic model. Only these scenarios show the effects that depend on earlier history. Examples are a staging value that stays hidden until a transfer, the exact synchronizer delay of `load_n`, the priority of a direct write over transparency, and waking from full shutdown.

// File: rtl/ocb_pkg.sv
// Package: shared opcode encoding and word layout constants for the
// octal code register bank. Assumes a fixed 2-bit pad and 3-bit opcode.
package ocb_pkg;
    localparam int PAD_W = 2;
    localparam int OP_W  = 3;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE      = 3'b000,
        OP_ZERO_ALL  = 3'b001,
        OP_POWER     = 3'b010,
        OP_PHASE_XFR = 3'b011,
        OP_BCAST_OUT = 3'b100,
        OP_STAGE_ONE = 3'b101,
        OP_WRITE_ONE = 3'b110,
        OP_XFER_ALL  = 3'b111
    } op_t;
endpackage

// File: rtl/ocb_load_sync.sv
// Module: brings the asynchronous active-low transfer pin into the clock
// domain through STAGES flops. Assumes STAGES >= 2; the flops reset to the
// idle (high) level so no transfer is seen during or right after reset.
module ocb_load_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic xfer_live
);
    logic [STAGES-1:0] chain_q;

    // Shift the pin level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], pin_n};
    end

    assign xfer_live = ~chain_q[STAGES-1];
endmodule

// File: rtl/ocb_cmd_decode.sv
// Module: turns one registered command word into per-channel and global
// write strobes. Purely combinational; assumes the word is held stable
// for the cycle in which cmd_vld is high.
module ocb_cmd_decode
    import ocb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CODE_W = 8,
    localparam int ADDR_W = $clog2(NUM_CH),
    localparam int BODY_W = ADDR_W + OP_W + CODE_W
) (
    input  logic              cmd_vld,
    input  logic [BODY_W-1:0] cmd_body,
    output logic [NUM_CH-1:0] stage_we,
    output logic [NUM_CH-1:0] out_we,
    output logic              zero_all,
    output logic              xfer_all,
    output logic              wake,
    output logic              power_set,
    output logic              phase_set,
    output logic              phase_val,
    output logic [CODE_W-1:0] wr_data
);
    localparam int OP_LSB   = CODE_W;
    localparam int ADDR_LSB = CODE_W + OP_W;

    op_t               op;
    logic [ADDR_W-1:0] addr;

    assign op      = op_t'(cmd_body[OP_LSB +: OP_W]);
    assign addr    = cmd_body[ADDR_LSB +: ADDR_W];
    assign wr_data = cmd_body[CODE_W-1:0];

    // Global strobes from the opcode alone.
    always_comb begin
        zero_all  = cmd_vld && (op == OP_ZERO_ALL);
        power_set = cmd_vld && (op == OP_POWER);
        phase_set = cmd_vld && (op == OP_PHASE_XFR);
        xfer_all  = cmd_vld && ((op == OP_PHASE_XFR) || (op == OP_XFER_ALL));
        wake      = cmd_vld && ((op == OP_ZERO_ALL) || (op == OP_BCAST_OUT)
                                || (op == OP_WRITE_ONE));
        phase_val = addr[ADDR_W-1];
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        logic hit;
        assign hit = (addr == ADDR_W'(i));
        // Per-channel write strobes from opcode and address match.
        always_comb begin
            stage_we[i] = cmd_vld && hit && ((op == OP_STAGE_ONE) || (op == OP_WRITE_ONE));
            out_we[i]   = cmd_vld && ((op == OP_BCAST_OUT) || (hit && (op == OP_WRITE_ONE)));
        end
    end
endmodule

// File: rtl/ocb_channel_regs.sv
// Module: one channel's staging and output code registers. Assumes the
// strobes are mutually consistent: zeroing wins, then a direct output
// write, then a transfer of the staging value (new value if written now).
module ocb_channel_regs #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              zero_all,
    input  logic              stage_we,
    input  logic              out_we,
    input  logic              xfer,
    input  logic [CODE_W-1:0] wr_data,
    output logic [CODE_W-1:0] stage_code,
    output logic [CODE_W-1:0] out_code
);
    logic [CODE_W-1:0] stage_nxt;
    logic [CODE_W-1:0] out_nxt;

    // Next-state selection for both registers.
    always_comb begin
        stage_nxt = stage_code;
        if (zero_all)      stage_nxt = '0;
        else if (stage_we) stage_nxt = wr_data;

        out_nxt = out_code;
        if (zero_all)    out_nxt = '0;
        else if (out_we) out_nxt = wr_data;
        else if (xfer)   out_nxt = stage_nxt;
    end

    // Register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_code <= '0;
            out_code   <= '0;
        end else begin
            stage_code <= stage_nxt;
            out_code   <= out_nxt;
        end
    end
endmodule

// File: rtl/octal_code_bank.sv
// Module: top of the double-buffered octal code register bank. Registers
// each strobed word, decodes it the following cycle, and keeps the enable
// mask, full-off flag and output phase bit. Assumes word_valid is a
// single-cycle strobe from a front end in the same clock domain.
module octal_code_bank
    import ocb_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W = $clog2(NUM_CH),
    localparam int BODY_W = ADDR_W + OP_W + CODE_W,
    localparam int WORD_W = PAD_W + BODY_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     word_valid,
    input  logic [WORD_W-1:0]        word,
    input  logic                     load_n,
    output logic [NUM_CH*CODE_W-1:0] dac_codes,
    output logic [NUM_CH-1:0]        en_mask,
    output logic                     all_off,
    output logic                     phase_rise
);
    logic                     cmd_vld_q;
    logic [BODY_W-1:0]        cmd_body_q;
    logic                     unused_pad;
    logic                     load_live;
    logic [NUM_CH-1:0]        stage_we;
    logic [NUM_CH-1:0]        out_we;
    logic                     zero_all;
    logic                     xfer_all;
    logic                     wake;
    logic                     power_set;
    logic                     phase_set;
    logic                     phase_val;
    logic [CODE_W-1:0]        wr_data;
    logic [NUM_CH*CODE_W-1:0] stage_flat;

    assign unused_pad = ^word[WORD_W-1 -: PAD_W];

    // Capture the word body so it is applied in the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_vld_q  <= 1'b0;
            cmd_body_q <= '0;
        end else begin
            cmd_vld_q  <= word_valid;
            if (word_valid) cmd_body_q <= word[BODY_W-1:0];
        end
    end

    ocb_load_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_n     (load_n),
        .xfer_live (load_live)
    );

    ocb_cmd_decode #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_dec (
        .cmd_vld   (cmd_vld_q),
        .cmd_body  (cmd_body_q),
        .stage_we  (stage_we),
        .out_we    (out_we),
        .zero_all  (zero_all),
        .xfer_all  (xfer_all),
        .wake      (wake),
        .power_set (power_set),
        .phase_set (phase_set),
        .phase_val (phase_val),
        .wr_data   (wr_data)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ocb_channel_regs #(.CODE_W(CODE_W)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .zero_all   (zero_all),
            .stage_we   (stage_we[i]),
            .out_we     (out_we[i]),
            .xfer       (xfer_all | load_live),
            .wr_data    (wr_data),
            .stage_code (stage_flat[i*CODE_W +: CODE_W]),
            .out_code   (dac_codes[i*CODE_W +: CODE_W])
        );
    end

    // Enable mask and full-off flag: wake restores, power command loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_mask <= '1;
            all_off <= 1'b0;
        end else if (wake) begin
            en_mask <= '1;
            all_off <= 1'b0;
        end else if (power_set) begin
            en_mask <= wr_data[NUM_CH-1:0];
            all_off <= (wr_data[NUM_CH-1:0] == '0);
        end
    end

    // Output launch-edge selection, changed only by its own opcode.
    always_ff @(posedge clk) begin
        if (!rst_n)         phase_rise <= 1'b0;
        else if (phase_set) phase_rise <= phase_val;
    end
endmodule

// File: rtl/octal_code_bank_chk.sv
// Module: assertion checker bound into octal_code_bank; observes ports and
// the registered command stage, staging codes and synchronized load level.
module octal_code_bank_chk
    import ocb_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CODE_W = 8,
    localparam int ADDR_W = $clog2(NUM_CH),
    localparam int BODY_W = ADDR_W + OP_W + CODE_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cmd_vld_q,
    input logic [BODY_W-1:0]        cmd_body_q,
    input logic                     load_live,
    input logic [NUM_CH*CODE_W-1:0] stage_flat,
    input logic [NUM_CH*CODE_W-1:0] dac_codes,
    input logic [NUM_CH-1:0]        en_mask,
    input logic                     all_off,
    input logic                     phase_rise
);
    logic [OP_W-1:0] op_q;
    logic            addr_msb_q;
    assign op_q       = cmd_body_q[CODE_W +: OP_W];
    assign addr_msb_q = cmd_body_q[BODY_W-1];

    // R2: an idle word leaves outputs alone when no transfer is live.
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_q && op_q == 3'b000 && !load_live)
        |=> ($stable(dac_codes) && $stable(en_mask) && $stable(phase_rise)));

    // R3: zeroing clears every output code and restores the mask.
    a_r3_zero_all: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_q && op_q == 3'b001) |=> (dac_codes == '0 && en_mask == '1 && !all_off));

    // R4: the full-off flag always agrees with the mask.
    a_r4_off_flag: assert property (@(posedge clk) disable iff (!rst_n)
        all_off == (en_mask == '0));

    // R5: phase command sets the launch edge from the address MSB.
    a_r5_phase_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_q && op_q == 3'b011) |=> (phase_rise == $past(addr_msb_q)));

    // R5: without the phase command the launch edge holds.
    a_r5_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_vld_q && op_q == 3'b011) |=> $stable(phase_rise));

    // R7: a staging-only write leaves all output codes unchanged.
    a_r7_stage_only: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_vld_q && op_q == 3'b101 && !load_live) |=> $stable(dac_codes));

    // R10: with the pin held low and no command, outputs equal staging.
    a_r10_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        (load_live && !cmd_vld_q) |=> (dac_codes == stage_flat));
endmodule

bind octal_code_bank octal_code_bank_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_vld_q  (cmd_vld_q),
    .cmd_body_q (cmd_body_q),
    .load_live  (load_live),
    .stage_flat (stage_flat),
    .dac_codes  (dac_codes),
    .en_mask    (en_mask),
    .all_off    (all_off),
    .phase_rise (phase_rise)
);

// File: tb/octal_code_bank_tb_top.sv
// Bench: sweeps every opcode at every address against an arithmetic model.
module octal_code_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [15:0] word = '0;
    logic        load_n = 1'b1;
    logic [63:0] dac_codes;
    logic [7:0]  en_mask;
    logic        all_off;
    logic        phase_rise;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] m_stage [8];
    logic [7:0] m_out   [8];
    logic [7:0] m_mask;
    logic       m_off;
    logic       m_phase;

    always #2.5 clk = ~clk;

    octal_code_bank dut_i (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word(word),
        .load_n(load_n), .dac_codes(dac_codes), .en_mask(en_mask),
        .all_off(all_off), .phase_rise(phase_rise)
    );

    function automatic logic [63:0] m_flat();
        logic [63:0] f;
        for (int i = 0; i < 8; i++) f[i*8 +: 8] = m_out[i];
        return f;
    endfunction

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0: return "R2";  3'd1: return "R3";  3'd2: return "R4";
            3'd3: return "R5";  3'd4: return "R6";  3'd5: return "R7";
            3'd6: return "R8";  default: return "R9";
        endcase
    endfunction

    task automatic check_all(input string tag);
        checks++;
        if (dac_codes !== m_flat() || en_mask !== m_mask || all_off !== m_off
            || phase_rise !== m_phase) begin
            failures++;
            $display("FAIL %s: codes=%h mask=%h off=%b ph=%b expected codes=%h mask=%h off=%b ph=%b",
                     tag, dac_codes, en_mask, all_off, phase_rise,
                     m_flat(), m_mask, m_off, m_phase);
        end
    endtask

    task automatic model_apply(input logic [2:0] op, input logic [2:0] a, input logic [7:0] d);
        case (op)
            3'd1: begin
                for (int i = 0; i < 8; i++) begin m_stage[i] = 0; m_out[i] = 0; end
                m_mask = 8'hFF; m_off = 0;
            end
            3'd2: begin m_mask = d; m_off = (d == 0); end
            3'd3: begin m_phase = a[2]; for (int i = 0; i < 8; i++) m_out[i] = m_stage[i]; end
            3'd4: begin for (int i = 0; i < 8; i++) m_out[i] = d; m_mask = 8'hFF; m_off = 0; end
            3'd5: m_stage[a] = d;
            3'd6: begin m_stage[a] = d; m_out[a] = d; m_mask = 8'hFF; m_off = 0; end
            3'd7: for (int i = 0; i < 8; i++) m_out[i] = m_stage[i];
            default: ;
        endcase
    endtask

    // R1: pad bits get arbitrary values; result is visible after the
    // edge that follows the capture edge.
    task automatic send(input logic [2:0] op, input logic [2:0] a,
                        input logic [7:0] d, input logic [1:0] pad);
        @(negedge clk);
        word = {pad, a, op, d};
        word_valid = 1'b1;
        @(negedge clk);
        word_valid = 1'b0;
        word = ~word;
        @(negedge clk);
        model_apply(op, a, d);
        if (!load_n) begin
            @(negedge clk);
            for (int i = 0; i < 8; i++) m_out[i] = m_stage[i];
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_stage[i] = 0; m_out[i] = 0; end
        m_mask = 8'hFF; m_off = 0; m_phase = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R11 reset state");

        // R1 R2..R9: every opcode at every address, data from the indices.
        for (int a = 0; a < 8; a++) begin
            for (int op = 0; op < 8; op++) begin
                logic [7:0] d;
                d = 8'((a * 37 + op * 11 + 5) & 8'hFF);
                send(3'(op), 3'(a), d, 2'(a + op));
                check_all({op_tag(3'(op)), " R1 sweep"});
            end
        end

        // R4: full shutdown, then R8 wake from it.
        send(3'd2, 3'd0, 8'h00, 2'b11);
        check_all("R4 full off");
        send(3'd6, 3'd3, 8'hC3, 2'b00);
        check_all("R8 wake from full off");

        // R7 then R9: staged values hidden until a transfer.
        send(3'd1, 3'd0, 8'h00, 2'b10);
        check_all("R3 clear before staging");
        for (int a = 0; a < 8; a++) begin
            send(3'd5, 3'(a), 8'(8'h10 + a * 8'h21), 2'b01);
            check_all("R7 staged, outputs unchanged");
        end
        send(3'd7, 3'd0, 8'h00, 2'b00);
        check_all("R9 software transfer");

        // R6 keeps staging: a later transfer restores staged values.
        send(3'd4, 3'd0, 8'hE7, 2'b00);
        check_all("R6 broadcast");
        send(3'd3, 3'd6, 8'h00, 2'b00);
        check_all("R5 phase rise with transfer");
        send(3'd3, 3'd1, 8'h00, 2'b00);
        check_all("R5 phase fall with transfer");

        // R10: synchronizer latency of the transfer pin.
        send(3'd5, 3'd2, 8'h5A, 2'b00);
        check_all("R7 stage before pin test");
        @(negedge clk);
        load_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_all("R10 still held two edges after pin low");
        @(negedge clk);
        m_out[2] = 8'h5A;
        check_all("R10 follows on third edge");

        // R10: pin low, staging writes propagate; direct write priority.
        send(3'd5, 3'd5, 8'h99, 2'b00);
        check_all("R10 staging write follows");
        @(negedge clk);
        word = {2'b00, 3'd4, 3'd4, 8'h3C};
        word_valid = 1'b1;
        @(negedge clk);
        word_valid = 1'b0;
        @(negedge clk);
        model_apply(3'd4, 3'd4, 8'h3C);
        check_all("R10 direct write wins its edge");
        @(negedge clk);
        for (int i = 0; i < 8; i++) m_out[i] = m_stage[i];
        check_all("R10 transparency resumes");
        load_n = 1'b1;
        repeat (3) @(negedge clk);
        send(3'd5, 3'd0, 8'h77, 2'b00);
        check_all("R7 pin released, outputs hold");

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule